// File: doc/BRIEF.md
# Configuration Lock and Operating Mode Controller

This block sits in the register file of a CAN controller. It guards a bank of protected configuration registers, such as bit timing and memory layout, that must not change while the node is active on the bus. It holds the two lock bits: an initialization bit, and a change-enable bit that can only be set once initialization is already on. It also holds a two-bit operating-mode field. For every host write it decides whether the addressed register may be updated. It drives the enable that lets the protocol engine take part in bus traffic.

A host unlocks configuration access in two steps. The first write sets the init bit. A second write, with init still set, sets the change-enable bit. The host then programs the protected registers and clears init to go back on the bus. Any change of operating mode forces init back on, so a mode switch never leaves the engine running on a half-written configuration. A protected write made while the lock is closed is dropped and flagged with a one-cycle pulse. A small bank of unprotected registers is always writable.

Top module: `cfg_guard`

## Requirements
- R1: After reset, init is 1, change-enable is 0, mode is 01 (standby), bus_en_o is 0, and every protected and unprotected register reads 0.
- R2: A write to a protected register (addresses 0x10 to 0x10+NUM_PROT-1) updates it only when init and change-enable were both 1 before that write; otherwise the register keeps its value.
- R3: A control write (address 0x00; bit 0 is init, bit 1 is change-enable) sets change-enable only when init was already 1 before the write. Writing 0b11 while init is 0 sets init alone.
- R4: A control write that clears init also clears change-enable in the same cycle.
- R5: A write to the mode register (address 0x01, bits [1:0]; 01 standby, 10 normal) with a legal value that differs from the current mode stores it and sets init. The codes 00 and 11 are ignored.
- R6: bus_en_o is 1 exactly when init is 0 and the mode is 10.
- R7: A blocked protected write drives wr_reject_o high for exactly the one cycle after the write edge. No other write raises it.
- R8: Unprotected registers (addresses 0x20 to 0x20+NUM_OPEN-1) accept every write, whatever the lock state.
- R9: rdata_o returns, combinationally for addr_i: the control value {cce, init} at 0x00, the mode at 0x01, and the register contents at the bank addresses. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| mode_o | output | 2 | Current operating mode |
| bus_en_o | output | 1 | Bus participation enable for the protocol engine |
| wr_reject_o | output | 1 | One-cycle pulse after a blocked protected write |
| prot_cfg_o | output | NUM_PROT*DATA_W | Protected register contents, register 0 in the low bits |

## Verification
A lock bit held in the wrong state shows up in two ways. A protected register takes data it should have dropped, or drops data it should have taken, and the next read of that address shows it. wr_reject_o also pulses, or stays low, one cycle after the write. A wrong init bit or a wrong mode changes bus_en_o one cycle after the write that caused it, and the control or mode readback shows the same fault. The bench therefore compares bus_en_o and wr_reject_o after every write, and reads back the registers often, so a fault is found within a few writes of its cause.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b01,
    MODE_NORMAL  = 2'b10
  } op_mode_e;

  localparam int unsigned CTRL_ADDR = 'h00;
  localparam int unsigned MODE_ADDR = 'h01;
  localparam int unsigned PROT_BASE = 'h10;
  localparam int unsigned OPEN_BASE = 'h20;
endpackage

// File: rtl/cfg_mode_ctrl.sv
module cfg_mode_ctrl
  import cfg_guard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  logic       mode_wr_i,
  input  logic [1:0] wbits_i,
  output logic       init_o,
  output logic       cce_o,
  output logic [1:0] mode_o
);
  logic       init_q, init_d;
  logic       cce_q, cce_d;
  logic [1:0] mode_q, mode_d;
  logic       mode_legal;

  assign mode_legal = (wbits_i == MODE_STANDBY) || (wbits_i == MODE_NORMAL);

  always_comb begin
    init_d = init_q;
    cce_d  = cce_q;
    mode_d = mode_q;
    if (ctrl_wr_i) begin
      init_d = wbits_i[0];
      // unlock needs init already set; dropping init relocks
      cce_d  = wbits_i[0] & wbits_i[1] & init_q;
    end else if (mode_wr_i && mode_legal && (wbits_i != mode_q)) begin
      mode_d = wbits_i;
      init_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      cce_q  <= 1'b0;
      mode_q <= MODE_STANDBY;
    end else begin
      init_q <= init_d;
      cce_q  <= cce_d;
      mode_q <= mode_d;
    end
  end

  assign init_o = init_q;
  assign cce_o  = cce_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned N      = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 'h10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                wr_allow_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                hit_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [N*DATA_W-1:0] regs_o
);
  logic [N-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign sel[i] = (addr_i == ADDR_W'(BASE + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (wr_en_i && wr_allow_i && sel[i]) q <= wdata_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q;
  end

  assign hit_o = |sel;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) rdata_o = regs_o[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PROT = 4,
  parameter int unsigned NUM_OPEN = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_en_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [1:0]                 mode_o,
  output logic                       bus_en_o,
  output logic                       wr_reject_o,
  output logic [NUM_PROT*DATA_W-1:0] prot_cfg_o
);
  localparam int unsigned PROT_W = NUM_PROT * DATA_W;
  localparam int unsigned OPEN_W = NUM_OPEN * DATA_W;

  logic              ctrl_hit, mode_hit, prot_hit, open_hit;
  logic              init_q, cce_q, unlocked;
  logic [1:0]        mode_q;
  logic [DATA_W-1:0] prot_rdata, open_rdata;
  logic [OPEN_W-1:0] open_regs;
  logic              reject_q;

  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));
  assign mode_hit = (addr_i == ADDR_W'(MODE_ADDR));
  assign unlocked = init_q & cce_q;

  cfg_mode_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (wr_en_i & ctrl_hit),
    .mode_wr_i (wr_en_i & mode_hit),
    .wbits_i   (wdata_i[1:0]),
    .init_o    (init_q),
    .cce_o     (cce_q),
    .mode_o    (mode_q)
  );

  cfg_reg_bank #(
    .N(NUM_PROT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(PROT_BASE)
  ) u_prot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_allow_i (unlocked),
    .wdata_i    (wdata_i),
    .hit_o      (prot_hit),
    .rdata_o    (prot_rdata),
    .regs_o     (prot_cfg_o)
  );

  cfg_reg_bank #(
    .N(NUM_OPEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(OPEN_BASE)
  ) u_open (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_allow_i (1'b1),
    .wdata_i    (wdata_i),
    .hit_o      (open_hit),
    .rdata_o    (open_rdata),
    .regs_o     (open_regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_q <= 1'b0;
    else         reject_q <= wr_en_i & prot_hit & ~unlocked;
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit)      rdata_o[1:0] = {cce_q, init_q};
    else if (mode_hit) rdata_o[1:0] = mode_q;
    else if (prot_hit) rdata_o = prot_rdata;
    else if (open_hit) rdata_o = open_rdata;
  end

  assign mode_o      = mode_q;
  assign bus_en_o    = ~init_q & (mode_q == MODE_NORMAL);
  assign wr_reject_o = reject_q;

  logic unused_open;
  assign unused_open = ^open_regs;

  localparam int unsigned CHK_W = PROT_W;
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int unsigned W = 128
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         prot_hit,
  input logic         init_q,
  input logic         cce_q,
  input logic [1:0]   mode_q,
  input logic         bus_en_o,
  input logic         wr_reject_o,
  input logic [W-1:0] prot_cfg_o
);
  a_r2_locked_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && prot_hit && !(init_q && cce_q)) |=> $stable(prot_cfg_o));

  a_r3_unlock_after_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cce_q) |-> $past(init_q));

  a_r4_relock_on_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_q) |-> !cce_q);

  a_r5_mode_change_inits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> init_q);

  a_r6_bus_needs_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> (mode_q == 2'b10) && !cce_q);

  a_r7_reject_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reject_o |-> $past(wr_en_i && prot_hit && !(init_q && cce_q)));
endmodule

bind cfg_guard cfg_guard_chk #(.W(CHK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .prot_hit    (prot_hit),
  .init_q      (init_q),
  .cce_q       (cce_q),
  .mode_q      (mode_q),
  .bus_en_o    (bus_en_o),
  .wr_reject_o (wr_reject_o),
  .prot_cfg_o  (prot_cfg_o)
);

// File: tb/cfg_guard_tb.sv
`timescale 1ns/1ps
module cfg_guard_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NP = 4;
  localparam int NO = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [1:0]        mode;
  logic              bus_en, wr_reject;
  logic [NP*DATA_W-1:0] prot_cfg;

  always #2 clk = ~clk;

  cfg_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NP), .NUM_OPEN(NO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .mode_o(mode), .bus_en_o(bus_en), .wr_reject_o(wr_reject),
    .prot_cfg_o(prot_cfg));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  bit          m_init, m_cce, m_rej;
  logic [1:0]  m_mode;
  logic [DATA_W-1:0] m_prot [NP];
  logic [DATA_W-1:0] m_open [NO];

  function automatic bit is_prot(logic [7:0] a);
    return a >= 8'h10 && a < 8'h10 + NP;
  endfunction
  function automatic bit is_open(logic [7:0] a);
    return a >= 8'h20 && a < 8'h20 + NO;
  endfunction
  function automatic logic [DATA_W-1:0] exp_read(logic [7:0] a);
    if (a == 8'h00) return {30'b0, m_cce, m_init};
    if (a == 8'h01) return {30'b0, m_mode};
    if (is_prot(a)) return m_prot[a - 8'h10];
    if (is_open(a)) return m_open[a - 8'h20];
    return '0;
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(logic [7:0] a, logic [DATA_W-1:0] d);
    m_rej = 1'b0;
    if (a == 8'h00) begin
      m_cce  = d[0] & d[1] & m_init;
      m_init = d[0];
    end else if (a == 8'h01) begin
      if ((d[1:0] == 2'b01 || d[1:0] == 2'b10) && d[1:0] != m_mode) begin
        m_mode = d[1:0];
        m_init = 1'b1;
      end
    end else if (is_prot(a)) begin
      if (m_init && m_cce) m_prot[a - 8'h10] = d;
      else m_rej = 1'b1;
    end else if (is_open(a)) begin
      m_open[a - 8'h20] = d;
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [DATA_W-1:0] d, string tag);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " R7 reject pulse"}, wr_reject, m_rej);
    chk({tag, " R6 bus_en"}, bus_en, ~m_init & (m_mode == 2'b10));
    @(negedge clk);
    chk({tag, " R7 pulse ends"}, wr_reject, 1'b0);
  endtask

  task automatic do_read(logic [7:0] a, string tag);
    @(negedge clk);
    addr = a;
    #0.5;
    chk({tag, " R9 read"}, rdata, exp_read(a));
  endtask

  initial begin
    m_init = 1; m_cce = 0; m_mode = 2'b01; m_rej = 0;
    for (int i = 0; i < NP; i++) m_prot[i] = '0;
    for (int i = 0; i < NO; i++) m_open[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_en", bus_en, 1'b0);
    chk("R1 mode", mode, 2'b01);
    chk("R1 reject", wr_reject, 1'b0);
    do_read(8'h00, "R1 ctrl");
    for (int i = 0; i < NP; i++) do_read(8'h10 + i[7:0], "R1 prot");
    for (int i = 0; i < NO; i++) do_read(8'h20 + i[7:0], "R1 open");

    // R2/R7: locked write blocked (init=1, cce=0)
    do_write(8'h11, 32'hDEAD0001, "R2 locked");
    do_read(8'h11, "R2 locked");
    // R8: open reg written while locked
    do_write(8'h20, 32'hA5A5A5A5, "R8 open");
    do_read(8'h20, "R8 open");
    // R3: leave init, then 0b11 from cleared sets init only
    do_write(8'h00, 32'h0, "R3 clear");
    do_write(8'h00, 32'h3, "R3 both");
    do_read(8'h00, "R3 init only");
    do_write(8'h12, 32'h12345678, "R2 init only");
    do_read(8'h12, "R2 init only");
    // second write unlocks
    do_write(8'h00, 32'h3, "R3 unlock");
    do_read(8'h00, "R3 unlocked");
    do_write(8'h12, 32'hCAFEF00D, "R2 unlocked");
    do_read(8'h12, "R2 unlocked");
    chk("R2 cfg out", prot_cfg[2*DATA_W +: DATA_W], 32'hCAFEF00D);
    // R4: clearing init clears cce
    do_write(8'h00, 32'h2, "R4 run");
    do_read(8'h00, "R4 relock");
    // R5: illegal modes ignored, then go normal
    do_write(8'h01, 32'h3, "R5 illegal");
    do_read(8'h01, "R5 illegal");
    do_write(8'h01, 32'h2, "R5 normal");
    do_read(8'h00, "R5 init set");
    chk("R5 mode", mode, 2'b10);
    do_write(8'h00, 32'h0, "R6 run");
    chk("R6 bus on", bus_en, 1'b1);
    do_write(8'h01, 32'h2, "R5 same mode");
    chk("R5 same mode keeps bus", bus_en, 1'b1);
    do_write(8'h01, 32'h1, "R5 standby");
    chk("R6 bus off", bus_en, 1'b0);
    do_read(8'h30, "R9 unmapped");

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [DATA_W-1:0] d;
      int pick = $urandom_range(0, 9);
      case (pick)
        0, 1: a = 8'h00;
        2:    a = 8'h01;
        3, 4, 5: a = 8'h10 + 8'($urandom_range(0, NP-1));
        6:    a = 8'h20 + 8'($urandom_range(0, NO-1));
        7:    a = 8'h30;
        default: a = 8'h10 + 8'($urandom_range(0, NP-1));
      endcase
      d = $urandom;
      do_write(a, d, "rnd R2");
      if (n % 4 == 0) do_read(a, "rnd R2");
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule